// File: doc/BRIEF.md
# Segment Bus Local Arbiter

One of these arbiters sits on each segment of a linearly segmented bus. It collects the request lines of the masters on its segment. For each request it decodes the segment field of the requested slave address. A local target gets the segment after a four-phase handshake: request up, grant up, request down, and the arbiter accepts no new request from that master until the request has gone low. A target on another segment is handed to the central arbiter through a request/acknowledge pair.

While a remote request waits for its acknowledge, other masters keep running local bursts. When the acknowledge arrives, the waiting master gets the bus only after the local burst in progress has ended. The arbiter counts the data words of every burst it grants, local or remote, and ends the burst when the count reaches the length the master presented. At the end of a remote burst it sends a one-cycle done pulse to the central arbiter. While the central arbiter holds the segment for a transfer from another segment, the arbiter starts no new burst. Data routing is outside this block.

Top module: `seg_local_arb`

## Requirements
- R1: While rst_ni is low and just after it is released, gnt_o, ca_req_o and ca_done_o are all zero.
- R2: A master's request is local when the top SEG_BITS bits of its address equal SEG_ID. Otherwise it is remote: ca_req_o rises in the cycle after the request, ca_tgt_o carries those top address bits, and the master is not granted.
- R3: An idle, unreserved segment grants a requesting local master in the cycle after the request. gnt_o is never more than one-hot.
- R4: A grant holds until the granted master has sent len words, counted on word_valid_i. The grant is zero in the cycle after the edge that takes the last word. A length of 0 means 2^LEN_W words.
- R5: After its burst ends, a master whose request is still high is not granted again until the request has been low for at least one clock edge.
- R6: Local masters are served round-robin. After master k is served, the search for the next grant starts at master k+1.
- R7: While a remote request is pending, another master's local request is granted.
- R8: ca_req_o stays high until ca_ack_i is sampled, then drops in the next cycle. If a local burst is running when the acknowledge arrives, the remote master is granted in the cycle after that burst ends.
- R9: While ext_busy_i is high, no new burst is granted, neither local nor remote.
- R10: ca_done_o is high for exactly one cycle, the cycle in which a remote burst's grant has just dropped. A local burst never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Segment clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MST | Per-master request level (four-phase) |
| addr_i | input | N_MST*ADDR_W | Per-master slave address, master m at bits m*ADDR_W upward |
| len_i | input | N_MST*LEN_W | Per-master burst length in words, 0 = 2^LEN_W |
| word_valid_i | input | 1 | The current owner puts a data word on the segment |
| ext_busy_i | input | 1 | Central arbiter holds the segment for a foreign transfer |
| gnt_o | output | N_MST | One-hot grant to a local master |
| ca_req_o | output | 1 | Request to the central arbiter |
| ca_tgt_o | output | SEG_BITS | Target segment of the pending remote request |
| ca_ack_i | input | 1 | Acknowledge from the central arbiter |
| ca_done_o | output | 1 | One-cycle end-of-remote-burst pulse |

## Verification
The bench builds the arbiter with four masters, an 8-bit address whose top 2 bits select one of four segments, a 3-bit length and an own segment index of 1. The short length field makes the length-0 case, 8 words, cheap to reach. Four masters are enough to show the round-robin search skipping a master that is waiting to drop its request, and a local burst running alongside a pending remote request. Remote targets both below and above the own index are included.

// File: rtl/seg_arb_pkg.sv
package seg_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOCAL  = 2'd1,
    ST_REMOTE = 2'd2
  } seg_state_e;
endpackage

// File: rtl/seg_addr_decode.sv
module seg_addr_decode #(
  parameter int N_MST    = 4,
  parameter int ADDR_W   = 8,
  parameter int SEG_BITS = 2,
  parameter int SEG_ID   = 1
) (
  input  logic [N_MST*ADDR_W-1:0]   addr_i,
  output logic [N_MST-1:0]          remote_o,
  output logic [N_MST*SEG_BITS-1:0] tgt_o
);
  for (genvar m = 0; m < N_MST; m++) begin : g_dec
    logic [SEG_BITS-1:0] seg;
    assign seg = addr_i[m*ADDR_W + ADDR_W - SEG_BITS +: SEG_BITS];
    assign tgt_o[m*SEG_BITS +: SEG_BITS] = seg;
    assign remote_o[m] = (seg != SEG_BITS'(SEG_ID));
  end
endmodule

// File: rtl/seg_rr_pick.sv
module seg_rr_pick #(
  parameter int N_MST = 4,
  localparam int IDX_W = $clog2(N_MST)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_MST-1:0] elig_i,
  input  logic             take_i,
  output logic [IDX_W-1:0] pick_o,
  output logic             any_o
);
  logic [IDX_W-1:0] ptr_q;

  always_comb begin
    any_o  = 1'b0;
    pick_o = '0;
    for (int i = 0; i < N_MST; i++) begin
      int j;
      j = (int'(ptr_q) + i) % N_MST;
      if (!any_o && elig_i[j]) begin
        any_o  = 1'b1;
        pick_o = IDX_W'(j);
      end
    end
  end

  // search restarts one past the last winner
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (take_i) ptr_q <= IDX_W'((int'(pick_o) + 1) % N_MST);
  end
endmodule

// File: rtl/seg_word_cnt.sv
module seg_word_cnt #(
  parameter int LEN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             word_i,
  output logic             last_o
);
  logic [LEN_W-1:0] len_q, cnt_q;

  // len 0 wraps to 2^LEN_W words through the modular compare
  assign last_o = word_i && (cnt_q == LEN_W'(len_q - 1'b1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      len_q <= len_i;
      cnt_q <= '0;
    end else if (word_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/seg_local_arb.sv
module seg_local_arb
  import seg_arb_pkg::*;
#(
  parameter int N_MST    = 4,
  parameter int ADDR_W   = 8,
  parameter int SEG_BITS = 2,
  parameter int LEN_W    = 3,
  parameter int SEG_ID   = 1,
  localparam int IDX_W   = $clog2(N_MST)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_MST-1:0]          req_i,
  input  logic [N_MST*ADDR_W-1:0]   addr_i,
  input  logic [N_MST*LEN_W-1:0]    len_i,
  input  logic                      word_valid_i,
  input  logic                      ext_busy_i,
  output logic [N_MST-1:0]          gnt_o,
  output logic                      ca_req_o,
  output logic [SEG_BITS-1:0]       ca_tgt_o,
  input  logic                      ca_ack_i,
  output logic                      ca_done_o
);
  localparam logic [N_MST-1:0] ONE = N_MST'(1);

  seg_state_e          state_q;
  logic [IDX_W-1:0]    owner_q, rem_idx_q, rr_pick, rem_sel;
  logic [N_MST-1:0]    rel_wait_q, remote, own_mask, pend_mask, loc_elig, rem_cand;
  logic [N_MST*SEG_BITS-1:0] tgt_all;
  logic                rem_pend_q, rem_ack_q, done_q, rr_any, rem_hit;
  logic                busy, start_loc, start_rem, last_word;
  logic [LEN_W-1:0]    start_len;
  logic [SEG_BITS-1:0] rem_tgt_q;

  seg_addr_decode #(
    .N_MST(N_MST), .ADDR_W(ADDR_W), .SEG_BITS(SEG_BITS), .SEG_ID(SEG_ID)
  ) u_dec (
    .addr_i  (addr_i),
    .remote_o(remote),
    .tgt_o   (tgt_all)
  );

  assign busy      = (state_q != ST_IDLE);
  assign own_mask  = busy ? (ONE << owner_q) : '0;
  assign pend_mask = rem_pend_q ? (ONE << rem_idx_q) : '0;
  assign loc_elig  = req_i & ~rel_wait_q & ~remote & ~own_mask & ~pend_mask;
  assign rem_cand  = req_i & ~rel_wait_q & remote & ~own_mask;

  // remote capture: lowest index wins, one pending slot
  always_comb begin
    rem_hit = 1'b0;
    rem_sel = '0;
    for (int i = N_MST - 1; i >= 0; i--) begin
      if (rem_cand[i]) begin
        rem_hit = 1'b1;
        rem_sel = IDX_W'(i);
      end
    end
  end

  seg_rr_pick #(.N_MST(N_MST)) u_rr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .elig_i(loc_elig),
    .take_i(start_loc),
    .pick_o(rr_pick),
    .any_o (rr_any)
  );

  // acknowledged remote master wins over new local work once idle
  assign start_rem = !busy && rem_ack_q && !ext_busy_i;
  assign start_loc = !busy && !rem_ack_q && !ext_busy_i && rr_any;
  assign start_len = start_rem ? len_i[rem_idx_q*LEN_W +: LEN_W]
                               : len_i[rr_pick*LEN_W +: LEN_W];

  seg_word_cnt #(.LEN_W(LEN_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_loc || start_rem),
    .len_i  (start_len),
    .word_i (busy && word_valid_i),
    .last_o (last_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      owner_q    <= '0;
      rel_wait_q <= '0;
      rem_pend_q <= 1'b0;
      rem_ack_q  <= 1'b0;
      rem_idx_q  <= '0;
      rem_tgt_q  <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q     <= last_word && (state_q == ST_REMOTE);
      rel_wait_q <= (rel_wait_q & req_i) | (last_word ? (ONE << owner_q) : '0);
      if (ca_req_o && ca_ack_i) rem_ack_q <= 1'b1;
      if (!rem_pend_q && rem_hit) begin
        rem_pend_q <= 1'b1;
        rem_idx_q  <= rem_sel;
        rem_tgt_q  <= tgt_all[rem_sel*SEG_BITS +: SEG_BITS];
      end
      if (start_rem) begin
        state_q <= ST_REMOTE;
        owner_q <= rem_idx_q;
      end else if (start_loc) begin
        state_q <= ST_LOCAL;
        owner_q <= rr_pick;
      end else if (last_word) begin
        if (state_q == ST_REMOTE) begin
          rem_pend_q <= 1'b0;
          rem_ack_q  <= 1'b0;
        end
        state_q <= ST_IDLE;
      end
    end
  end

  assign gnt_o     = own_mask;
  assign ca_req_o  = rem_pend_q && !rem_ack_q;
  assign ca_tgt_o  = rem_tgt_q;
  assign ca_done_o = done_q;
endmodule

// File: rtl/seg_local_arb_chk.sv
module seg_local_arb_chk #(
  parameter int N_MST    = 4,
  parameter int SEG_BITS = 2,
  parameter int SEG_ID   = 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [N_MST-1:0]    gnt_o,
  input logic                ca_req_o,
  input logic [SEG_BITS-1:0] ca_tgt_o,
  input logic                ca_ack_i,
  input logic                ca_done_o,
  input logic                ext_busy_i,
  input logic                word_valid_i
);
  assert_gnt_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  assert_hold_no_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && !word_valid_i) |=> $stable(gnt_o));

  assert_tgt_remote_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ca_req_o |-> (ca_tgt_o != SEG_BITS'(SEG_ID)));

  assert_req_until_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ca_req_o && !ca_ack_i) |=> ca_req_o);

  assert_req_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ca_req_o && ca_ack_i) |=> !ca_req_o);

  assert_busy_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_busy_i && gnt_o == '0) |=> (gnt_o == '0));

  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ca_done_o |=> !ca_done_o);

  assert_done_at_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ca_done_o |-> ($past(gnt_o) != '0 && gnt_o == '0));
endmodule

bind seg_local_arb seg_local_arb_chk #(
  .N_MST(N_MST), .SEG_BITS(SEG_BITS), .SEG_ID(SEG_ID)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .gnt_o       (gnt_o),
  .ca_req_o    (ca_req_o),
  .ca_tgt_o    (ca_tgt_o),
  .ca_ack_i    (ca_ack_i),
  .ca_done_o   (ca_done_o),
  .ext_busy_i  (ext_busy_i),
  .word_valid_i(word_valid_i)
);

// File: tb/seg_local_arb_test.sv
module seg_local_arb_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int AW = 8;
  localparam int LW = 3;

  typedef struct packed {
    logic [1:0] mst;
    logic [7:0] addr;
    logic [2:0] len;
    logic       is_local;
  } vec_t;

  // own segment 1 => addresses 0x40..0x7F are local
  localparam vec_t VECS [7] = '{
    '{2'd0, 8'h40, 3'd1, 1'b1},
    '{2'd1, 8'h7F, 3'd3, 1'b1},
    '{2'd2, 8'h00, 3'd2, 1'b0},
    '{2'd3, 8'h55, 3'd0, 1'b1},
    '{2'd1, 8'h80, 3'd1, 1'b0},
    '{2'd0, 8'hBF, 3'd2, 1'b0},
    '{2'd3, 8'hC1, 3'd3, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  req = '0;
  logic [N*AW-1:0] addr = '0;
  logic [N*LW-1:0] len = '0;
  logic          wv = 1'b0, ext_busy = 1'b0, ack = 1'b0;
  logic [N-1:0]  gnt;
  logic          ca_req, ca_done;
  logic [1:0]    ca_tgt;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_local_arb #(.N_MST(N), .ADDR_W(AW), .SEG_BITS(2), .LEN_W(LW), .SEG_ID(1)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .addr_i(addr), .len_i(len),
    .word_valid_i(wv), .ext_busy_i(ext_busy), .gnt_o(gnt), .ca_req_o(ca_req),
    .ca_tgt_o(ca_tgt), .ca_ack_i(ack), .ca_done_o(ca_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_mst(input int m, input logic [7:0] a, input logic [2:0] l);
    addr[m*AW +: AW] = a;
    len[m*LW +: LW]  = l;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; req = '0; wv = 1'b0; ack = 1'b0; ext_busy = 1'b0;
    tick();
    chk("R1 gnt in reset", 32'(gnt), 0);
    chk("R1 ca_req in reset", 32'(ca_req), 0);
    chk("R1 ca_done in reset", 32'(ca_done), 0);
    rst_ni = 1'b1;
    tick();
    chk("R1 gnt after reset", 32'(gnt), 0);
  endtask

  // drive words until the grant drops; grant checked before each word
  task automatic run_words(input string tag, input int m, input int n, input logic exp_done);
    wv = 1'b1;
    for (int k = 0; k < n - 1; k++) begin
      tick();
      chk({tag, " R4 grant held"}, 32'(gnt), 32'(1 << m));
    end
    tick();
    chk({tag, " R4 grant dropped"}, 32'(gnt), 0);
    chk({tag, " R10 done"}, 32'(ca_done), 32'(exp_done));
    wv = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();

    // vector walk: single master transactions, local and remote (R2 R3 R4 R10)
    for (int v = 0; v < 7; v++) begin
      int m, n;
      m = int'(VECS[v].mst);
      n = (VECS[v].len == 0) ? 8 : int'(VECS[v].len);
      set_mst(m, VECS[v].addr, VECS[v].len);
      req[m] = 1'b1;
      tick();
      if (VECS[v].is_local) begin
        chk("R3 local grant", 32'(gnt), 32'(1 << m));
        chk("R2 no central req", 32'(ca_req), 0);
        run_words("vec local", m, n, 1'b0);
      end else begin
        chk("R2 remote not granted", 32'(gnt), 0);
        chk("R2 central req", 32'(ca_req), 1);
        chk("R2 target field", 32'(ca_tgt), 32'(VECS[v].addr[7:6]));
        ack = 1'b1;
        tick();
        ack = 1'b0;
        chk("R8 req drops after ack", 32'(ca_req), 0);
        tick();
        chk("R8 remote grant", 32'(gnt), 32'(1 << m));
        run_words("vec remote", m, n, 1'b1);
        tick();
        chk("R10 done one cycle", 32'(ca_done), 0);
      end
      req[m] = 1'b0;
      tick();
    end

    // R5: four-phase release
    do_reset();
    set_mst(2, 8'h48, 3'd1);
    req[2] = 1'b1;
    tick();
    chk("R5 first grant", 32'(gnt), 32'h4);
    run_words("R5", 2, 1, 1'b0);
    tick(); tick();
    chk("R5 no regrant while req high", 32'(gnt), 0);
    req[2] = 1'b0;
    tick();
    req[2] = 1'b1;
    tick();
    chk("R5 regrant after req drop", 32'(gnt), 32'h4);
    run_words("R5b", 2, 1, 1'b0);
    req[2] = 1'b0;
    tick();

    // R6: round-robin
    do_reset();
    set_mst(0, 8'h41, 3'd1);
    set_mst(1, 8'h42, 3'd2);
    set_mst(2, 8'h43, 3'd1);
    req[2:0] = 3'b111;
    tick();
    chk("R6 first winner m0", 32'(gnt), 32'h1);
    run_words("R6 m0", 0, 1, 1'b0);
    tick();
    chk("R6 next winner m1", 32'(gnt), 32'h2);
    req[0] = 1'b0;
    wv = 1'b1;
    tick();
    req[0] = 1'b1;
    chk("R6 m1 held", 32'(gnt), 32'h2);
    tick();
    wv = 1'b0;
    chk("R6 m1 done", 32'(gnt), 0);
    tick();
    chk("R6 m2 before re-raised m0", 32'(gnt), 32'h4);
    run_words("R6 m2", 2, 1, 1'b0);
    req[2:1] = 2'b00;
    tick();
    chk("R6 m0 after wrap", 32'(gnt), 32'h1);
    run_words("R6 m0b", 0, 1, 1'b0);
    req = '0;
    tick();

    // R7 R8: local burst overlaps a pending remote request
    do_reset();
    set_mst(3, 8'hC5, 3'd2);
    set_mst(1, 8'h60, 3'd3);
    req[3] = 1'b1;
    req[1] = 1'b1;
    tick();
    chk("R7 local granted with remote pending", 32'(gnt), 32'h2);
    chk("R7 central req raised", 32'(ca_req), 1);
    chk("R2 target seg 3", 32'(ca_tgt), 3);
    ack = 1'b1;
    wv = 1'b1;
    tick();
    ack = 1'b0;
    chk("R8 req drops after ack", 32'(ca_req), 0);
    chk("R8 local keeps bus", 32'(gnt), 32'h2);
    tick();
    chk("R8 local still holds", 32'(gnt), 32'h2);
    tick();
    wv = 1'b0;
    chk("R8 local ended", 32'(gnt), 0);
    chk("R10 no done on local end", 32'(ca_done), 0);
    req[1] = 1'b0;
    tick();
    chk("R8 remote granted after local", 32'(gnt), 32'h8);
    run_words("R8 remote", 3, 2, 1'b1);
    tick();
    chk("R10 done cleared", 32'(ca_done), 0);
    req = '0;
    tick();

    // R9: central reservation blocks new grants
    do_reset();
    ext_busy = 1'b1;
    set_mst(0, 8'h44, 3'd2);
    req[0] = 1'b1;
    tick(); tick(); tick();
    chk("R9 no grant while reserved", 32'(gnt), 0);
    ext_busy = 1'b0;
    tick();
    chk("R9 grant after release", 32'(gnt), 32'h1);
    run_words("R9", 0, 2, 1'b0);
    req = '0;
    tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule